// File: doc/BRIEF.md
# Dual-Port Collision Detector with Busy Address Capture

This block watches the access stream of two ports that share one memory array and share one clock. Each port presents two enables, a write strobe and an address every cycle. The block registers these accesses and compares them. It raises a busy flag when the ports meet on the same location in the same cycle, or when one port touches a location in the cycle right after the other port touched it, provided at least one of the two accesses is a write. The flag goes to the port that loses. Port A wins a tie in the same cycle. When the accesses fall on consecutive cycles, the earlier access wins.

The address of the first such collision is held in a capture register next to a valid bit, and the host sees both on outputs. A readback strobe on either port empties the register. It then stays closed for a short hold-off window and re-arms. The first collision whose later access falls after that window is the next one captured. The array itself and data arbitration live elsewhere.

Top module: `dp_collide_det`

## Requirements
- R1: With rst_n low at a clock edge, after that edge both busy flags are high (inactive), cap_vld is 0, cap_addr is 0, and capture is armed with no hold-off.
- R2: A port's access counts only when both of its enables (en0 and en1) are 1 at the sampling edge. An access with either enable at 0 never causes a busy flag and is never captured.
- R3: If both ports make a valid access to the same address at the same edge and at least one writes, b_busy_n is 0 and a_busy_n stays 1. The flag is driven from the edge that follows the sampling edge and holds for one cycle.
- R4: If port A accesses an address at edge j-1 and port B accesses the same address at edge j, with at least one write, b_busy_n is 0 after edge j+1. In the mirrored case, with B first and A second, a_busy_n is 0 after edge j+1.
- R5: A match in which both accesses are reads never drives a busy flag low and is never captured.
- R6: The first collision captured while cap_vld is 0 loads its address into cap_addr and sets cap_vld to 1, at the same edge that drives the busy flag. Later collisions leave cap_addr unchanged while cap_vld is 1.
- R7: A readback strobe (a_rdbk or b_rdbk) that is 1 at edge k clears cap_vld at edge k. Readback takes precedence over a capture at the same edge.
- R8: After a readback at edge k, a collision whose later access is sampled at edge k or k+1 is not captured. One sampled at edge k+2 or later is captured.
- R9: A busy flag returns to 1 at the first edge whose evaluated access pair has no collision for that port. No state stretches the flag.
- R10: Under mixed random traffic, every output matches, cycle by cycle, a model built from R1 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| a_en0 | input | 1 | Port A enable 0 |
| a_en1 | input | 1 | Port A enable 1 |
| a_wr | input | 1 | Port A write strobe (1 = write) |
| a_addr | input | AW | Port A address |
| a_rdbk | input | 1 | Port A busy-address readback strobe |
| b_en0 | input | 1 | Port B enable 0 |
| b_en1 | input | 1 | Port B enable 1 |
| b_wr | input | 1 | Port B write strobe (1 = write) |
| b_addr | input | AW | Port B address |
| b_rdbk | input | 1 | Port B busy-address readback strobe |
| a_busy_n | output | 1 | Port A lost a collision (active low) |
| b_busy_n | output | 1 | Port B lost a collision (active low) |
| cap_addr | output | AW | Captured collision address |
| cap_vld | output | 1 | Capture register holds an address |

## Verification
The hardest case to reach is a collision that lands exactly one or two edges after a readback while the capture register is empty. Random traffic almost never lines these up, because it also needs a free capture register and a write on a shared address. Directed sequences therefore issue a readback and then place write collisions at the k+1 and k+2 edges. Other directed runs cover mirrored back-to-back pairs and a same-cycle tie together with a back-to-back pair. After these, seeded random traffic on a four-address window keeps collisions frequent.

// File: rtl/dpcd_pkg.sv
// Shared types for the dual-port collision detector.
// Assumes exactly two ports, indexed by port_e.
package dpcd_pkg;
    localparam int NPORTS = 2;

    typedef enum logic {
        PORT_A = 1'b0,
        PORT_B = 1'b1
    } port_e;

    // Kinds of collision found in one evaluation cycle.
    typedef struct packed {
        logic same;      // both ports at the same edge, A wins the tie
        logic a_then_b;  // A one edge earlier, B loses
        logic b_then_a;  // B one edge earlier, A loses
    } hit_t;
endpackage

// File: rtl/dpcd_port_pipe.sv
// Per-port access register: holds the access sampled at the latest edge
// and the one before it. Assumes an access is valid only with both enables.
module dpcd_port_pipe #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en0,
    input  logic          en1,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic          cur_vld,
    output logic          cur_wr,
    output logic [AW-1:0] cur_addr,
    output logic          prv_vld,
    output logic          prv_wr,
    output logic [AW-1:0] prv_addr
);
    // Shift the current access into the previous slot and sample the new one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_vld  <= 1'b0;
            cur_wr   <= 1'b0;
            cur_addr <= '0;
            prv_vld  <= 1'b0;
            prv_wr   <= 1'b0;
            prv_addr <= '0;
        end else begin
            prv_vld  <= cur_vld;
            prv_wr   <= cur_wr;
            prv_addr <= cur_addr;
            cur_vld  <= en0 & en1;
            cur_wr   <= wr;
            cur_addr <= addr;
        end
    end
endmodule

// File: rtl/dpcd_match.sv
// Compares two registered accesses. A hit needs both valid, equal
// addresses and at least one write. Purely combinational.
module dpcd_match #(
    parameter int AW = 10
) (
    input  logic          x_vld,
    input  logic          x_wr,
    input  logic [AW-1:0] x_addr,
    input  logic          y_vld,
    input  logic          y_wr,
    input  logic [AW-1:0] y_addr,
    output logic          hit
);
    // Qualify an address match by validity and write presence.
    always_comb begin
        hit = x_vld && y_vld && (x_addr == y_addr) && (x_wr || y_wr);
    end
endmodule

// File: rtl/dpcd_capture.sv
// Busy address register with readback re-arm. After a readback, captures
// are held off for HOLD evaluations. Assumes the readback strobe is
// already synchronous to clk.
module dpcd_capture #(
    parameter int AW   = 10,
    parameter int HOLD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [AW-1:0] hit_addr,
    input  logic          rdbk,
    output logic [AW-1:0] cap_addr,
    output logic          cap_vld
);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [HW-1:0] HOLD_LD = HW'(HOLD);

    logic [HW-1:0] hold_q;
    logic          take;

    // A capture is allowed when empty, armed and a hit is present.
    always_comb begin
        take = hit && !cap_vld && (hold_q == '0) && !rdbk;
    end

    // Hold-off counter: reload on readback, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            hold_q <= '0;
        else if (rdbk)         hold_q <= HOLD_LD;
        else if (hold_q != '0) hold_q <= hold_q - 1'b1;
    end

    // Capture register: clear on readback, load on the first armed hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld  <= 1'b0;
            cap_addr <= '0;
        end else if (rdbk) begin
            cap_vld  <= 1'b0;
        end else if (take) begin
            cap_vld  <= 1'b1;
            cap_addr <= hit_addr;
        end
    end
endmodule

// File: rtl/dp_collide_det.sv
// Top of the dual-port collision detector. Registers each port's access,
// finds same-edge and back-to-back collisions with a write, drives the
// loser's active-low busy flag one cycle later and captures the first
// collision address. Assumes both ports share clk.
module dp_collide_det
    import dpcd_pkg::*;
#(
    parameter int AW   = 10,
    parameter int HOLD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en0,
    input  logic          a_en1,
    input  logic          a_wr,
    input  logic [AW-1:0] a_addr,
    input  logic          a_rdbk,
    input  logic          b_en0,
    input  logic          b_en1,
    input  logic          b_wr,
    input  logic [AW-1:0] b_addr,
    input  logic          b_rdbk,
    output logic          a_busy_n,
    output logic          b_busy_n,
    output logic [AW-1:0] cap_addr,
    output logic          cap_vld
);
    logic          p_en0  [NPORTS];
    logic          p_en1  [NPORTS];
    logic          p_wr   [NPORTS];
    logic [AW-1:0] p_addr [NPORTS];
    logic          c_vld  [NPORTS];
    logic          c_wr   [NPORTS];
    logic [AW-1:0] c_addr [NPORTS];
    logic          r_vld  [NPORTS];
    logic          r_wr   [NPORTS];
    logic [AW-1:0] r_addr [NPORTS];

    hit_t          hits;
    logic          any_hit;
    logic [AW-1:0] hit_addr;

    // Gather the two port inputs into indexed arrays.
    always_comb begin
        p_en0[PORT_A]  = a_en0;  p_en0[PORT_B]  = b_en0;
        p_en1[PORT_A]  = a_en1;  p_en1[PORT_B]  = b_en1;
        p_wr[PORT_A]   = a_wr;   p_wr[PORT_B]   = b_wr;
        p_addr[PORT_A] = a_addr; p_addr[PORT_B] = b_addr;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        dpcd_port_pipe #(.AW(AW)) i_pipe (
            .clk      (clk),
            .rst_n    (rst_n),
            .en0      (p_en0[p]),
            .en1      (p_en1[p]),
            .wr       (p_wr[p]),
            .addr     (p_addr[p]),
            .cur_vld  (c_vld[p]),
            .cur_wr   (c_wr[p]),
            .cur_addr (c_addr[p]),
            .prv_vld  (r_vld[p]),
            .prv_wr   (r_wr[p]),
            .prv_addr (r_addr[p])
        );
    end

    dpcd_match #(.AW(AW)) i_same (
        .x_vld (c_vld[PORT_A]), .x_wr (c_wr[PORT_A]), .x_addr (c_addr[PORT_A]),
        .y_vld (c_vld[PORT_B]), .y_wr (c_wr[PORT_B]), .y_addr (c_addr[PORT_B]),
        .hit   (hits.same)
    );

    dpcd_match #(.AW(AW)) i_a_then_b (
        .x_vld (r_vld[PORT_A]), .x_wr (r_wr[PORT_A]), .x_addr (r_addr[PORT_A]),
        .y_vld (c_vld[PORT_B]), .y_wr (c_wr[PORT_B]), .y_addr (c_addr[PORT_B]),
        .hit   (hits.a_then_b)
    );

    dpcd_match #(.AW(AW)) i_b_then_a (
        .x_vld (r_vld[PORT_B]), .x_wr (r_wr[PORT_B]), .x_addr (r_addr[PORT_B]),
        .y_vld (c_vld[PORT_A]), .y_wr (c_wr[PORT_A]), .y_addr (c_addr[PORT_A]),
        .hit   (hits.b_then_a)
    );

    // Pick the colliding address: the loser's current address.
    always_comb begin
        any_hit  = hits.same | hits.a_then_b | hits.b_then_a;
        hit_addr = (hits.same | hits.a_then_b) ? c_addr[PORT_B] : c_addr[PORT_A];
    end

    // Register the active-low busy flags for the losing port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_busy_n <= 1'b1;
            b_busy_n <= 1'b1;
        end else begin
            a_busy_n <= ~hits.b_then_a;
            b_busy_n <= ~(hits.same | hits.a_then_b);
        end
    end

    dpcd_capture #(.AW(AW), .HOLD(HOLD)) i_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (any_hit),
        .hit_addr (hit_addr),
        .rdbk     (a_rdbk | b_rdbk),
        .cap_addr (cap_addr),
        .cap_vld  (cap_vld)
    );
endmodule

// File: rtl/dpcd_chk.sv
// Assertion checker for dp_collide_det, attached with bind below.
// Observes only the top-level ports.
module dpcd_chk #(
    parameter int AW   = 10,
    parameter int HOLD = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_en0,
    input logic          a_en1,
    input logic          a_wr,
    input logic [AW-1:0] a_addr,
    input logic          a_rdbk,
    input logic          b_en0,
    input logic          b_en1,
    input logic          b_wr,
    input logic [AW-1:0] b_addr,
    input logic          b_rdbk,
    input logic          a_busy_n,
    input logic          b_busy_n,
    input logic [AW-1:0] cap_addr,
    input logic          cap_vld
);
    logic rb;
    assign rb = a_rdbk | b_rdbk;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (a_busy_n && b_busy_n && !cap_vld && cap_addr == '0));

    a_r2_a_off_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_en0 && a_en1) |-> ##2 a_busy_n);

    a_r2_b_off_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_en0 && b_en1) |-> ##2 b_busy_n);

    a_r3_same_edge_b_loses: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en0 && a_en1 && b_en0 && b_en1 && a_addr == b_addr && (a_wr || b_wr))
        |-> ##2 !b_busy_n);

    a_r7_readback_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rb |=> !cap_vld);

    a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        rb |-> ##3 !cap_vld);

    a_r6_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vld && !rb) |=> ($stable(cap_addr) && cap_vld));
endmodule

bind dp_collide_det dpcd_chk #(.AW(AW), .HOLD(HOLD)) i_chk (.*);

// File: tb/test_dp_collide_det.sv
`timescale 1ns/1ps
module test_dp_collide_det;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_en0 = 0, a_en1 = 0, a_wr = 0, a_rdbk = 0;
    logic b_en0 = 0, b_en1 = 0, b_wr = 0, b_rdbk = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic a_busy_n, b_busy_n, cap_vld;
    logic [AW-1:0] cap_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    string req = "R1";

    always #2.5 clk = ~clk;

    dp_collide_det #(.AW(AW), .HOLD(2)) i_dp_collide_det (.*);

    // Reference model state, built from the requirements.
    bit            sv[2], sw[2], pv[2], pw[2];
    bit [AW-1:0]   sa[2], pa[2];
    bit            m_busy_a_n = 1, m_busy_b_n = 1, m_vld = 0;
    bit [AW-1:0]   m_addr = '0;
    int            m_hold = 0;

    function automatic bit coll(bit v0, bit w0, bit [AW-1:0] a0,
                                bit v1, bit w1, bit [AW-1:0] a1);
        return v0 && v1 && (a0 == a1) && (w0 || w1);
    endfunction

    always @(posedge clk) begin
        bit same, ab, ba;
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin
                sv[p] = 0; sw[p] = 0; sa[p] = '0; pv[p] = 0; pw[p] = 0; pa[p] = '0;
            end
            m_busy_a_n = 1; m_busy_b_n = 1; m_vld = 0; m_addr = '0; m_hold = 0;
        end else begin
            same = coll(sv[0], sw[0], sa[0], sv[1], sw[1], sa[1]);
            ab   = coll(pv[0], pw[0], pa[0], sv[1], sw[1], sa[1]);
            ba   = coll(pv[1], pw[1], pa[1], sv[0], sw[0], sa[0]);
            m_busy_a_n = !ba;
            m_busy_b_n = !(same || ab);
            if (a_rdbk || b_rdbk) begin
                m_vld = 0; m_hold = 2;
            end else begin
                if ((same || ab || ba) && !m_vld && m_hold == 0) begin
                    m_vld = 1;
                    m_addr = (same || ab) ? sa[1] : sa[0];
                end
                if (m_hold > 0) m_hold--;
            end
            for (int p = 0; p < 2; p++) begin
                pv[p] = sv[p]; pw[p] = sw[p]; pa[p] = sa[p];
            end
            sv[0] = a_en0 && a_en1; sw[0] = a_wr; sa[0] = a_addr;
            sv[1] = b_en0 && b_en1; sw[1] = b_wr; sa[1] = b_addr;
        end
    end

    task automatic check_all();
        n_chk++;
        if (a_busy_n !== m_busy_a_n || b_busy_n !== m_busy_b_n ||
            cap_vld !== m_vld || (m_vld && cap_addr !== m_addr)) begin
            n_fail++;
            $display("FAIL %s: got busy_a_n=%0b busy_b_n=%0b vld=%0b addr=%0h exp %0b %0b %0b %0h",
                     req, a_busy_n, b_busy_n, cap_vld, cap_addr,
                     m_busy_a_n, m_busy_b_n, m_vld, m_addr);
        end
    endtask

    task automatic expect_bit(string r, bit act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b exp %0b", r, act, exp);
        end
    endtask

    // Drive one cycle (called at a negedge), then check after the next edge.
    task automatic step(bit ae, bit aw, int aa, bit be, bit bw, int ba, bit rb);
        a_en0 = ae; a_en1 = ae; a_wr = aw; a_addr = AW'(aa);
        b_en0 = be; b_en1 = be; b_wr = bw; b_addr = AW'(ba);
        a_rdbk = rb; b_rdbk = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        req = "R1";
        expect_bit("R1", a_busy_n, 1); expect_bit("R1", b_busy_n, 1);
        expect_bit("R1", cap_vld, 0);  expect_bit("R1", cap_addr == 0, 1);
        rst_n = 1;

        // R2: one enable low on port A, same address as B writing.
        req = "R2";
        a_en0 = 1; a_en1 = 0; a_wr = 1; a_addr = 10'h55;
        b_en0 = 1; b_en1 = 1; b_wr = 1; b_addr = 10'h55;
        @(posedge clk); @(negedge clk); check_all();
        a_en0 = 0; a_en1 = 0; b_en0 = 0; b_en1 = 0;
        @(posedge clk); @(negedge clk); check_all();
        expect_bit("R2", b_busy_n, 1); expect_bit("R2", cap_vld, 0);
        idle(2);

        // R5: read-read match.
        req = "R5";
        step(1, 0, 7, 1, 0, 7, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        expect_bit("R5", a_busy_n & b_busy_n, 1); expect_bit("R5", cap_vld, 0);

        // R3 and R6: same-edge write collision, B loses, address captured.
        req = "R3";
        step(1, 1, 9, 1, 0, 9, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        expect_bit("R3", b_busy_n, 0); expect_bit("R3", a_busy_n, 1);
        req = "R6";
        expect_bit("R6", cap_vld, 1); expect_bit("R6", cap_addr == 9, 1);
        req = "R9";
        step(0, 0, 0, 0, 0, 0, 0);
        expect_bit("R9", b_busy_n, 1);

        // R6: a second collision leaves the captured address alone.
        req = "R6";
        step(1, 1, 3, 1, 1, 3, 0);
        idle(2);
        expect_bit("R6", cap_addr == 9, 1);

        // R4: A then B, then B then A.
        req = "R7";
        step(0, 0, 0, 0, 0, 0, 1);
        expect_bit("R7", cap_vld, 0);
        idle(3);
        req = "R4";
        step(1, 1, 20, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 20, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        expect_bit("R4", b_busy_n, 0); expect_bit("R4", a_busy_n, 1);
        step(0, 0, 0, 1, 1, 21, 1);
        step(1, 0, 21, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        expect_bit("R4", a_busy_n, 0); expect_bit("R4", b_busy_n, 1);
        idle(3);

        // R8: readback at edge k, collisions at k+1 (blocked) then k+2 (taken).
        req = "R8";
        step(0, 0, 0, 0, 0, 0, 1);
        step(1, 1, 30, 1, 1, 30, 0);
        idle(2);
        expect_bit("R8", cap_vld, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 31, 1, 1, 31, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        expect_bit("R8", cap_vld, 1); expect_bit("R8", cap_addr == 31, 1);

        // R3 with a back-to-back pair on the same edge.
        req = "R3";
        step(1, 1, 40, 0, 0, 0, 0);
        step(1, 0, 40, 1, 1, 40, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        expect_bit("R3", b_busy_n, 0);

        // R10: seeded random traffic on a narrow address window.
        req = "R10";
        for (int i = 0; i < 3000; i++) begin
            a_en0 = ($urandom % 8) != 0; a_en1 = ($urandom % 8) != 0;
            b_en0 = ($urandom % 8) != 0; b_en1 = ($urandom % 8) != 0;
            a_wr = $urandom % 2; b_wr = $urandom % 2;
            a_addr = AW'($urandom % 4); b_addr = AW'($urandom % 4);
            a_rdbk = ($urandom % 16) == 0; b_rdbk = ($urandom % 16) == 0;
            if ((i % 500) == 499) rst_n = 0; else rst_n = 1;
            @(posedge clk); @(negedge clk);
            check_all();
        end
        finish_run();
    end
endmodule